// File: doc/BRIEF.md
# Quadrature Reference Phase Generator

The block turns one external square-wave reference into a pair of square waves at the same frequency, one aligned with the reference and one a quarter period behind it. These can drive a pair of synchronous demodulators. The reference is brought into the fast system clock through a two-flop synchronizer. Only its rising edges are used. The block counts how many clock ticks lie between successive rising edges and keeps one quarter of that count, found with a two-bit right shift. A second counter then marks quarter-period points inside the next period. Each marker, together with the reference edge itself, toggles a double-rate flip-flop. The in-phase output follows the rising transitions of that flip-flop and the quadrature output follows its falling transitions.

A divide select slows the counting rate by a power of two. This lets long reference periods fit into the period counter. A valid flag reports when the measured period is usable, and the measured count is shown on a port.

Top module: `quad_ref_gen`

## Requirements
- R1: While reset is high, and on the first clock after it, `i_o`, `q_o` and `valid_o` are 0 and `period_o` is 0.
- R2: The reference passes two synchronizer flops. If the clock edge that first samples `ref_i` high is edge k, a rising edge is recognised in the cycle after edge k+1. At edge k+2, `i_o` becomes 1 and `q_o` becomes 0.
- R3: At the edge where `i_o` is set by a reference edge, `period_o` takes the number of counting steps since the previous reference edge, plus one. The counter restarts at 1 on each edge. Between edges, `period_o` holds its value.
- R4: With `div_sel_i` = k, both counters advance once every 2^k clocks. The divide phase restarts on every reference edge. With k = 0 a period of N clocks reads N.
- R5: The quarter value Q is the period count shifted right by two, taken at each edge. In the following period, a match pulse fires each time the second counter, which restarts at 1 on the edge and after every match, equals Q on a counting step. At most three match pulses fire per period, and none fires in an edge cycle. The next edge supplies the fourth tick.
- R6: `i_o` is 1 from the reference-edge tick until the second match pulse of the period, and 0 after that.
- R7: `q_o` goes to 1 on the first match pulse and back to 0 on the third.
- R8: Only rising reference edges matter. Any duty cycle with the same rising-edge spacing gives the same `i_o`, `q_o` and `period_o`.
- R9: `valid_o` becomes 1 at an edge only when this measurement and the one before are both at least MIN_PERIOD (8) and not saturated. Any other measurement clears it.
- R10: The period counter stops at 2^CNT_W−1 (32767). One clock after it reaches that value, `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_i | input | 1 | Asynchronous reference square wave |
| div_sel_i | input | DIV_SEL_W | Counting-rate divide select, rate = clock / 2^div_sel_i |
| i_o | output | 1 | In-phase (0°) square wave |
| q_o | output | 1 | Quadrature (90° lag) square wave |
| period_o | output | CNT_W | Last measured period in counting steps |
| valid_o | output | 1 | Measured period is usable |

## Verification
A rising level on `ref_i` sampled at edge k first shows up at edge k+2. At that edge, `i_o`, `q_o`, `period_o` and `valid_o` all change together. Each match pulse moves `i_o` or `q_o` at the edge that ends its cycle. Saturation clears `valid_o` one edge after the counter tops out. The bench model follows the same edge-by-edge timing for every register on the path. Inputs are driven and outputs compared on the falling clock edge, so each result is checked in the cycle it is due.

// File: rtl/qrg_pkg.sv
package qrg_pkg;

    // Width of the divide-phase counter for a given select width.
    function automatic int unsigned pre_width(input int unsigned sel_w);
        int unsigned w;
        w = (1 << sel_w) - 1;
        return (w == 0) ? 1 : w;
    endfunction

    // Number of match pulses allowed in one reference period.
    localparam int unsigned EQ_PER_PERIOD = 3;

endpackage

// File: rtl/qrg_sync_edge.sv
module qrg_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ref_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], ref_i};
        st_d.last = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign rise_o = st_q.sh[STAGES-1] & ~st_q.last;
endmodule

// File: rtl/qrg_period_meas.sv
module qrg_period_meas
    import qrg_pkg::*;
#(
    parameter int unsigned CNT_W      = 15,
    parameter int unsigned DIV_SEL_W  = 2,
    parameter int unsigned MIN_PERIOD = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 rise_i,
    input  logic [DIV_SEL_W-1:0] div_sel_i,
    output logic                 ce_o,
    output logic [CNT_W-1:0]     quarter_o,
    output logic [CNT_W-1:0]     period_o,
    output logic [CNT_W-1:0]     count_o,
    output logic                 valid_o
);
    localparam int unsigned PRE_W   = pre_width(DIV_SEL_W);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_PERIOD);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] quarter;
        logic [CNT_W-1:0] period;
        logic             streak;
        logic             valid;
    } meas_t;

    meas_t st_d, st_q;
    logic [PRE_W-1:0] pre_lim;
    logic             ce;
    logic             good;

    always_comb begin
        pre_lim = PRE_W'((32'd1 << div_sel_i) - 32'd1);
        ce      = (st_q.pre == pre_lim);
        good    = (st_q.cnt != CNT_MAX) && (st_q.cnt >= CNT_MIN);
        st_d    = st_q;
        if (rise_i) begin
            st_d.pre     = '0;
            st_d.cnt     = CNT_W'(1);
            st_d.quarter = st_q.cnt >> 2;
            st_d.period  = st_q.cnt;
            st_d.valid   = good && st_q.streak;
            st_d.streak  = good;
        end else begin
            st_d.pre = ce ? '0 : st_q.pre + PRE_W'(1);
            if (ce && st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == CNT_MAX) begin
                st_d.valid  = 1'b0;
                st_d.streak = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q     <= '0;
            st_q.cnt <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign ce_o      = ce;
    assign quarter_o = st_q.quarter;
    assign period_o  = st_q.period;
    assign count_o   = st_q.cnt;
    assign valid_o   = st_q.valid;
endmodule

// File: rtl/qrg_phase_gen.sv
module qrg_phase_gen
    import qrg_pkg::*;
#(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rise_i,
    input  logic             ce_i,
    input  logic [CNT_W-1:0] quarter_i,
    output logic             i_o,
    output logic             q_o,
    output logic             eq_o,
    output logic [1:0]       eq_seen_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [1:0]       EQ_LIM  = 2'(EQ_PER_PERIOD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [1:0]       seen;
        logic             dbl;
        logic             i;
        logic             q;
    } phase_t;

    phase_t st_d, st_q;
    logic   eq;

    always_comb begin
        eq   = !rise_i && ce_i && (st_q.cnt == quarter_i) && (st_q.seen != EQ_LIM);
        st_d = st_q;
        if (rise_i) begin
            st_d.cnt  = CNT_W'(1);
            st_d.seen = '0;
            st_d.dbl  = 1'b1;
            st_d.i    = 1'b1;
            st_d.q    = 1'b0;
        end else if (eq) begin
            st_d.cnt  = CNT_W'(1);
            st_d.seen = st_q.seen + 2'd1;
            st_d.dbl  = ~st_q.dbl;
            if (!st_q.dbl) st_d.i = ~st_q.i;
            else           st_d.q = ~st_q.q;
        end else if (ce_i && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q     <= '0;
            st_q.cnt <= CNT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign i_o       = st_q.i;
    assign q_o       = st_q.q;
    assign eq_o      = eq;
    assign eq_seen_o = st_q.seen;
endmodule

// File: rtl/quad_ref_gen.sv
module quad_ref_gen #(
    parameter int unsigned CNT_W      = 15,
    parameter int unsigned DIV_SEL_W  = 2,
    parameter int unsigned MIN_PERIOD = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 ref_i,
    input  logic [DIV_SEL_W-1:0] div_sel_i,
    output logic                 i_o,
    output logic                 q_o,
    output logic [CNT_W-1:0]     period_o,
    output logic                 valid_o
);
    logic             rise_w;
    logic             ce_w;
    logic [CNT_W-1:0] quarter_w;
    logic [CNT_W-1:0] per_cnt_w;
    logic             eq_w;
    logic [1:0]       eq_seen_w;

    qrg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ref_i  (ref_i),
        .rise_o (rise_w)
    );

    qrg_period_meas #(
        .CNT_W      (CNT_W),
        .DIV_SEL_W  (DIV_SEL_W),
        .MIN_PERIOD (MIN_PERIOD)
    ) u_meas (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rise_i    (rise_w),
        .div_sel_i (div_sel_i),
        .ce_o      (ce_w),
        .quarter_o (quarter_w),
        .period_o  (period_o),
        .count_o   (per_cnt_w),
        .valid_o   (valid_o)
    );

    qrg_phase_gen #(.CNT_W(CNT_W)) u_phase (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rise_i    (rise_w),
        .ce_i      (ce_w),
        .quarter_i (quarter_w),
        .i_o       (i_o),
        .q_o       (q_o),
        .eq_o      (eq_w),
        .eq_seen_o (eq_seen_w)
    );
endmodule

// File: rtl/qrg_checker.sv
module qrg_checker #(
    parameter int unsigned CNT_W      = 15,
    parameter int unsigned MIN_PERIOD = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             rise_i,
    input logic             eq_i,
    input logic [1:0]       eq_seen_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             i_i,
    input logic             q_i,
    input logic             valid_i,
    input logic [CNT_W-1:0] period_i
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_PERIOD);

    a_r1_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (!i_i && !q_i && !valid_i && period_i == '0));

    a_r2_edge_sets_i: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_i |=> (i_i && !q_i));

    a_r3_period_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        !rise_i |=> $stable(period_i));

    a_r5_eq_limit: assert property (@(posedge clk_i) disable iff (rst_i)
        eq_i |-> (eq_seen_i != 2'd3));

    a_r5_no_eq_on_edge: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_i |-> !eq_i);

    a_r9_valid_range: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |-> (period_i >= CNT_MIN && period_i != CNT_MAX));

    a_r10_sat_drops_valid: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_i == CNT_MAX) |=> !valid_i);
endmodule

bind quad_ref_gen qrg_checker #(
    .CNT_W      (CNT_W),
    .MIN_PERIOD (MIN_PERIOD)
) u_qrg_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rise_i    (rise_w),
    .eq_i      (eq_w),
    .eq_seen_i (eq_seen_w),
    .cnt_i     (per_cnt_w),
    .i_i       (i_o),
    .q_i       (q_o),
    .valid_i   (valid_o),
    .period_i  (period_o)
);

// File: tb/tb_quad_ref_gen.sv
module tb_quad_ref_gen;
    localparam int CNT_W = 15;
    localparam int DSW   = 2;
    localparam int MAXV  = (1 << CNT_W) - 1;
    localparam int WDOG  = 150000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ref_s = 1'b0;
    logic [DSW-1:0] div_sel = '0;
    logic           i_w, q_w, valid_w;
    logic [CNT_W-1:0] period_w;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int trans = 0;
    logic [1:0] iq_prev = 2'b00;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    quad_ref_gen #(.CNT_W(CNT_W), .DIV_SEL_W(DSW)) dut (
        .clk_i(clk), .rst_i(rst), .ref_i(ref_s), .div_sel_i(div_sel),
        .i_o(i_w), .q_o(q_w), .period_o(period_w), .valid_o(valid_w)
    );

    // Behavioural reference model, one step per clock edge.
    int  m_sync[$];
    bit  m_last;
    int  m_pre, m_per, m_qtr, m_period, m_c2, m_seen;
    bit  m_valid, m_streak, m_dbl, m_i, m_q;

    always @(posedge clk) begin
        bit rise, ce, eq, good;
        int lim;
        if (rst) begin
            m_sync = {0, 0}; m_last = 0;
            m_pre = 0; m_per = MAXV; m_qtr = 0; m_period = 0;
            m_c2 = 1; m_seen = 0;
            m_valid = 0; m_streak = 0; m_dbl = 0; m_i = 0; m_q = 0;
        end else begin
            rise = (m_sync[1] == 1) && !m_last;
            lim  = (1 << div_sel) - 1;
            ce   = (m_pre == lim);
            eq   = !rise && ce && (m_c2 == m_qtr) && (m_seen < 3);
            if (rise) begin
                good = (m_per != MAXV) && (m_per >= 8);
                m_qtr = m_per / 4; m_period = m_per;
                m_valid = good && m_streak; m_streak = good;
                m_per = 1; m_pre = 0;
                m_c2 = 1; m_seen = 0; m_dbl = 1; m_i = 1; m_q = 0;
            end else begin
                if (m_per == MAXV) begin m_valid = 0; m_streak = 0; end
                if (ce && m_per != MAXV) m_per++;
                m_pre = ce ? 0 : m_pre + 1;
                if (eq) begin
                    m_c2 = 1; m_seen++;
                    m_dbl = !m_dbl;
                    if (m_dbl) m_i = !m_i; else m_q = !m_q;
                end else if (ce && m_c2 != MAXV) m_c2++;
            end
            m_last = (m_sync[1] == 1);
            m_sync = {int'(ref_s), m_sync[0]};
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(i_w == m_i, "R6 i_o", int'(i_w), int'(m_i));
            chk(q_w == m_q, "R7 q_o", int'(q_w), int'(m_q));
            chk(int'(period_w) == m_period, "R3 period_o", int'(period_w), m_period);
            chk(valid_w == m_valid, "R9 valid_o", int'(valid_w), int'(m_valid));
        end
        if ({i_w, q_w} != iq_prev) trans++;
        iq_prev = {i_w, q_w};
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
            summary();
        end
    end

    task automatic run_ref(input int hi, input int lo, input int n);
        for (int k = 0; k < n; k++) begin
            ref_s = 1'b1;
            repeat (hi) @(negedge clk);
            ref_s = 1'b0;
            repeat (lo) @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!i_w && !q_w && !valid_w && period_w == 0, "R1 reset state",
            int'({i_w, q_w, valid_w}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!i_w && !q_w && !valid_w && period_w == 0, "R1 after release",
            int'({i_w, q_w, valid_w}), 0);

        // R2: latency from sampled reference to i_o
        ref_s = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!i_w, "R2 i_o not yet", int'(i_w), 0);
        @(negedge clk);
        chk(i_w && !q_w, "R2 i_o set", int'({i_w, q_w}), 2);
        ref_s = 1'b0;
        repeat (37) @(negedge clk);

        // Period 40, 50% duty
        run_ref(20, 20, 6);
        chk(period_w == 40, "R3 period 40", int'(period_w), 40);
        chk(valid_w, "R9 valid after good edges", int'(valid_w), 1);
        trans = 0;
        run_ref(20, 20, 5);
        chk(trans == 20, "R5 four ticks per period", trans, 20);

        // R8: period 42 with different duty cycles
        run_ref(10, 32, 4);
        chk(period_w == 42, "R8 period 42 short high", int'(period_w), 42);
        run_ref(32, 10, 4);
        chk(period_w == 42, "R8 period 42 long high", int'(period_w), 42);

        // R4: divide by 4, period 100 clocks reads 25
        div_sel = 2'd2;
        run_ref(50, 50, 5);
        chk(period_w == 25, "R4 divided period", int'(period_w), 25);
        div_sel = 2'd0;
        run_ref(30, 30, 3);
        chk(period_w == 60, "R4 undivided period", int'(period_w), 60);

        // R9: too-short period clears valid
        run_ref(3, 3, 8);
        chk(!valid_w, "R9 short period invalid", int'(valid_w), 0);
        run_ref(20, 20, 4);
        chk(valid_w, "R9 valid regained", int'(valid_w), 1);

        // R10: saturation with the reference held low
        ref_s = 1'b0;
        repeat (MAXV + 200) @(negedge clk);
        chk(!valid_w, "R10 saturated invalid", int'(valid_w), 0);
        run_ref(20, 20, 1);
        chk(period_w == MAXV, "R10 saturated count", int'(period_w), MAXV);
        chk(!valid_w, "R10 still invalid", int'(valid_w), 0);
        run_ref(20, 20, 3);
        chk(valid_w, "R9 recovers after saturation", int'(valid_w), 1);

        done = 1;
        summary();
    end
endmodule